// File: doc/BRIEF.md
# Alarm Status and Interrupt Controller

This block collects four live alarm conditions from a clock-generation subsystem: initialization busy, loss of lock on two PLLs (A and B), and loss of the input reference. Each alarm arrives asynchronously and passes through its own synchronizer. The synchronized value can be read as a live status byte. A rising edge of an alarm sets a latched copy that software must acknowledge. A per-source mask decides which latched bits may pull the active-low interrupt line.

The same byte-wide register port also holds a PLL reset control. Writing a one to one of its bits fires a single-cycle reset pulse toward the matching PLL, and the bit never reads back as set. All three alarm registers share one bit layout, so a value read from one register can be used directly as the mask or acknowledge pattern for another. The register map is: live status at 0x00, latched alarms at 0x01, mask at 0x02 and PLL reset control at 0x10.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, the status, latch and mask registers read 0x00, `irq_n` is 1, and both PLL reset pulses are 0.
- R2: The status register (0x00) returns the synchronized alarms as follows: init busy at bit 7, PLL B unlock at bit 6, PLL A unlock at bit 5 and reference loss at bit 4. Bits 3:2 read 0 and bits 1:0 hold the `REV_ID` parameter (default 0). Writes to it have no effect.
- R3: A latch bit (0x01, same layout as R2) sets on the rising edge of its synchronized alarm and stays set after the alarm drops.
- R4: Writing 0 to a latch bit clears it. Writing 1 leaves it unchanged.
- R5: A clear is ignored for any bit whose synchronized alarm is still high in the cycle of the write.
- R6: The mask register (0x02) stores bits 7:4 in the R2 layout. Bits 3:0 read 0 whatever was written.
- R7: `irq_n` is a registered output. It is 0 exactly one clock after any latch bit is set while its mask bit is 0, and 1 otherwise.
- R8: Writing to 0x10 with bit 7 set gives a one-cycle `pll_b_rst` pulse. Bit 5 set gives a one-cycle `pll_a_rst` pulse. The pulse is high for the clock after the write. The register always reads 0x00.
- R9: `rd_data` is registered. It updates on the clock edge where `rd_en` is high, with the addressed register's value, and holds otherwise. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_in | input | 4 | Async alarms: [3] init busy, [2] PLL B unlock, [1] PLL A unlock, [0] reference loss |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |
| pll_a_rst | output | 1 | One-cycle reset pulse for PLL A |
| pll_b_rst | output | 1 | One-cycle reset pulse for PLL B |

## Verification
The bench walks a table of alarm and mask combinations. This shows whether each alarm lands on the correct latch bit and whether masking gates the interrupt: a swapped field or inverted mask shows as a wrong latch byte or a wrong `irq_n` level. Directed cases cover the following:
- An acknowledge written while the alarm is still active. A design that clears anyway would drop the bit and silence the interrupt.
- Writing ones to the latch, where a design that treats 1 as clear would lose pending alarms.
- Writes to the read-only status register and to the low mask bits, which must leave no trace.
- The reset control, where a level instead of a pulse, a wrong bit-to-PLL mapping, or a bit that reads back set would each be caught.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_ALARMS = 4;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 8;
  // Alarm fields occupy the upper nibble; alarm index i maps to bit FIELD_LSB+i
  localparam int FIELD_LSB  = 4;
  localparam int REV_W      = 2;
  localparam int PLLB_BIT   = 7;
  localparam int PLLA_BIT   = 5;

  localparam logic [ADDR_W-1:0] A_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] A_LATCH  = 8'h01;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h02;
  localparam logic [ADDR_W-1:0] A_PLLRST = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_LATCH, SEL_MASK, SEL_PLLRST
  } reg_sel_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] live,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_in[i]};
    end
    assign live[i] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= live;
  end

  assign rise = live & ~prev_q;

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] live,
  input  logic [N-1:0] rise,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_keep,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] latch_q,
  output logic [N-1:0] mask_q,
  output logic         irq_n
);
  for (genvar i = 0; i < N; i++) begin : g_latch
    logic drop;
    // clear only if written 0 and the condition has gone away
    assign drop = clr_stb & ~clr_keep[i] & ~live[i];
    always_ff @(posedge clk) begin
      if (rst)          latch_q[i] <= 1'b0;
      else if (rise[i]) latch_q[i] <= 1'b1;
      else if (drop)    latch_q[i] <= 1'b0;
    end

    assert_set_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> latch_q[i]);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (latch_q[i] && !clr_stb) |=> latch_q[i]);
    assert_keep_live_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_stb && live[i]) |=> latch_q[i]);
    assert_keep_one_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_stb && clr_keep[i] && latch_q[i]) |=> latch_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(latch_q & ~mask_q);
  end

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    ((latch_q & ~mask_q) != '0) |=> !irq_n);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ((latch_q & ~mask_q) == '0) |=> irq_n);
endmodule

// File: rtl/alarm_reg_port.sv
module alarm_reg_port
  import alarm_irq_pkg::*;
#(
  parameter logic [REV_W-1:0] REV_ID = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  rd_en,
  input  logic [NUM_ALARMS-1:0] live,
  input  logic [NUM_ALARMS-1:0] latch_q,
  input  logic [NUM_ALARMS-1:0] mask_q,
  output logic [REG_W-1:0]      rd_data,
  output logic                  clr_stb,
  output logic                  mask_wr,
  output logic [NUM_ALARMS-1:0] field_wdata,
  output logic                  pll_a_rst,
  output logic                  pll_b_rst
);
  localparam int PAD_W = FIELD_LSB - REV_W;

  reg_sel_e sel;
  logic [REG_W-1:0] rd_next;
  logic rst_hit;

  always_comb begin
    unique case (addr)
      A_STATUS: sel = SEL_STATUS;
      A_LATCH:  sel = SEL_LATCH;
      A_MASK:   sel = SEL_MASK;
      A_PLLRST: sel = SEL_PLLRST;
      default:  sel = SEL_NONE;
    endcase
  end

  assign field_wdata = wr_data[FIELD_LSB +: NUM_ALARMS];
  assign clr_stb     = wr_en && (sel == SEL_LATCH);
  assign mask_wr     = wr_en && (sel == SEL_MASK);
  assign rst_hit     = wr_en && (sel == SEL_PLLRST);

  always_comb begin
    case (sel)
      SEL_STATUS: rd_next = {live,    {PAD_W{1'b0}}, REV_ID};
      SEL_LATCH:  rd_next = {latch_q, {FIELD_LSB{1'b0}}};
      SEL_MASK:   rd_next = {mask_q,  {FIELD_LSB{1'b0}}};
      default:    rd_next = '0; // reset control self-clears, unmapped reads 0
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_a_rst <= 1'b0;
      pll_b_rst <= 1'b0;
    end else begin
      pll_a_rst <= rst_hit & wr_data[PLLA_BIT];
      pll_b_rst <= rst_hit & wr_data[PLLB_BIT];
    end
  end

  assert_pulse_a_R8: assert property (@(posedge clk) disable iff (rst)
    (pll_a_rst && !(rst_hit && wr_data[PLLA_BIT])) |=> !pll_a_rst);
  assert_pulse_b_R8: assert property (@(posedge clk) disable iff (rst)
    (pll_b_rst && !(rst_hit && wr_data[PLLB_BIT])) |=> !pll_b_rst);
  assert_fire_b_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_hit && wr_data[PLLB_BIT]) |=> pll_b_rst);
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_rst_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_PLLRST) |=> (rd_data == '0));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [REV_W-1:0]  REV_ID      = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_ALARMS-1:0] alarm_in,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  rd_en,
  output logic [REG_W-1:0]      rd_data,
  output logic                  irq_n,
  output logic                  pll_a_rst,
  output logic                  pll_b_rst
);
  logic [NUM_ALARMS-1:0] live, rise, latch_q, mask_q, field_wdata;
  logic clr_stb, mask_wr;

  alarm_sync #(.N(NUM_ALARMS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(alarm_in), .live(live), .rise(rise)
  );

  alarm_latch_bank #(.N(NUM_ALARMS)) u_bank (
    .clk(clk), .rst(rst), .live(live), .rise(rise),
    .clr_stb(clr_stb), .clr_keep(field_wdata),
    .mask_wr(mask_wr), .mask_wdata(field_wdata),
    .latch_q(latch_q), .mask_q(mask_q), .irq_n(irq_n)
  );

  alarm_reg_port #(.REV_ID(REV_ID)) u_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .live(live), .latch_q(latch_q), .mask_q(mask_q),
    .rd_data(rd_data), .clr_stb(clr_stb), .mask_wr(mask_wr),
    .field_wdata(field_wdata), .pll_a_rst(pll_a_rst), .pll_b_rst(pll_b_rst)
  );

  assert_reset_irq_R1: assert property (@(posedge clk)
    rst |=> (irq_n && !pll_a_rst && !pll_b_rst && rd_data == '0));
endmodule

// File: tb/alarm_irq_ctrl_bench.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] alarm_in = '0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n, pll_a_rst, pll_b_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alarm_irq_ctrl u_alarm_irq_ctrl (
    .clk(clk), .rst(rst), .alarm_in(alarm_in), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n),
    .pll_a_rst(pll_a_rst), .pll_b_rst(pll_b_rst)
  );

  // {alarm[3:0], mask nibble, expected latch byte, expected irq_n}
  localparam logic [16:0] VEC [6] = '{
    {4'b1000, 4'b0000, 8'h80, 1'b0},
    {4'b0100, 4'b0100, 8'h40, 1'b1},
    {4'b0011, 4'b0001, 8'h30, 1'b0},
    {4'b1111, 4'b1111, 8'hF0, 1'b1},
    {4'b0001, 4'b1110, 8'h10, 1'b0},
    {4'b0000, 4'b0000, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 pll pulses", {6'd0, pll_a_rst, pll_b_rst}, 8'h00);
    rd(8'h00, v); chk("R1 status", v, 8'h00);
    rd(8'h01, v); chk("R1 latch", v, 8'h00);
    rd(8'h02, v); chk("R1 mask", v, 8'h00);

    // table walk: R3 latch layout, R6 mask, R7 interrupt
    for (int k = 0; k < 6; k++) begin
      wr(8'h01, 8'h00);
      wr(8'h02, {VEC[k][12:9], 4'h0});
      @(negedge clk); alarm_in = VEC[k][16:13];
      idle(3);
      alarm_in = '0;
      idle(5);
      rd(8'h01, v); chk("R3 latch after pulse", v, VEC[k][8:1]);
      chk("R7 irq_n vs mask", {7'd0, irq_n}, {7'd0, VEC[k][0]});
      rd(8'h02, v); chk("R6 mask readback", v, {VEC[k][12:9], 4'h0});
    end

    // R4: writing ones keeps, zero clears
    wr(8'h02, 8'h00);
    wr(8'h01, 8'h00);
    @(negedge clk); alarm_in = 4'b1000; idle(3); alarm_in = '0; idle(5);
    wr(8'h01, 8'hFF);
    rd(8'h01, v); chk("R4 write one keeps", v, 8'h80);
    wr(8'h01, 8'h7F);
    rd(8'h01, v); chk("R4 write zero clears", v, 8'h00);
    idle(1);
    chk("R7 irq released", {7'd0, irq_n}, 8'h01);

    // R2 live status layout and R5 clear blocked while live
    @(negedge clk); alarm_in = 4'b0101; idle(4);
    rd(8'h00, v); chk("R2 live status", v, 8'h50);
    wr(8'h00, 8'hFF);
    rd(8'h00, v); chk("R2 status write ignored", v, 8'h50);
    wr(8'h01, 8'h00);
    rd(8'h01, v); chk("R5 clear while live", v, 8'h50);
    chk("R5 irq held", {7'd0, irq_n}, 8'h00);
    alarm_in = '0; idle(4);
    rd(8'h00, v); chk("R2 status drops", v, 8'h00);
    wr(8'h01, 8'h00);
    rd(8'h01, v); chk("R5 clear after drop", v, 8'h00);

    // R6 low mask bits ignored
    wr(8'h02, 8'h0F);
    rd(8'h02, v); chk("R6 low bits", v, 8'h00);

    // R8 reset pulses
    wr(8'h10, 8'h80);
    chk("R8 B pulse", {6'd0, pll_a_rst, pll_b_rst}, 8'h01);
    @(negedge clk);
    chk("R8 B single cycle", {6'd0, pll_a_rst, pll_b_rst}, 8'h00);
    wr(8'h10, 8'h20);
    chk("R8 A pulse", {6'd0, pll_a_rst, pll_b_rst}, 8'h02);
    @(negedge clk);
    chk("R8 A single cycle", {6'd0, pll_a_rst, pll_b_rst}, 8'h00);
    wr(8'h10, 8'h5F);
    chk("R8 other bits no pulse", {6'd0, pll_a_rst, pll_b_rst}, 8'h00);
    wr(8'h10, 8'hA0);
    rd(8'h10, v); chk("R8 reads zero", v, 8'h00);

    // R9 unmapped read and hold
    rd(8'h33, v); chk("R9 unmapped", v, 8'h00);
    idle(2);
    chk("R9 hold", rd_data, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule